// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register face of a serial port. A CPU reaches it through a simple single-cycle bus slave that decodes a 4 KB window as 32-bit words. Through it software can identify the port, pop received bytes, see how full the receive queue is, choose which events raise the interrupt line, and program the pointers and lengths that the transmit and receive DMA movers work from. A write to the data word sends one byte out on a transmit byte stream.

Received bytes come in on a valid/ready byte input. While a receive DMA has bytes outstanding, each incoming byte goes to the DMA output with its target address. Otherwise the byte is queued in a circular receive FIFO of configurable depth. Starting a receive DMA first hands the bytes already queued to the DMA output, one per cycle, oldest first. The DMA data movers themselves, and the line encoding, sit outside this block.

Top module: `sport_front`

## Requirements
- R1: After a synchronous active-low reset the FIFO is empty, the interrupt enables, both DMA pointers and the outstanding receive count are zero, read data is zero, `irq`, `err_flag`, `tx_valid`, `dma_tx_go` and `rxdma_valid` are low, and `rx_ready` is high.
- R2: The word index is `bus_addr` (byte offset bits [11:2]). Index 0 reads `ID_VALUE`, index 8 reads the FIFO depth, and index 5 always reads 0. Read data appears on `bus_rdata` one clock after the access and holds until the next read.
- R3: A read of index 1 (data) with a non-empty FIFO returns the oldest byte, zero-extended, and removes it. Bytes leave in arrival order across pointer wraparound.
- R4: A read of index 1 with an empty FIFO returns 0xFFFFFFFF and leaves the count at zero. Index 2 reads the current FIFO count.
- R5: Index 3 holds a 3-bit enable mask, with the upper write bits dropped. `irq` is high when bit 0 is set and the FIFO is non-empty, or when bit 1 is set, or when bit 2 is set and the outstanding receive DMA count is zero.
- R6: A write to index 1 pulses `tx_valid` for one cycle in the next clock, with `tx_byte` equal to write-data bits [7:0].
- R7: `rx_ready` is high when the outstanding receive count is non-zero or the FIFO holds fewer than its depth. It is low while queued bytes are being handed to DMA, and during a write to index 7. A byte accepted with no receive DMA outstanding is queued.
- R8: A byte accepted while the outstanding receive count is non-zero is not queued. In the next cycle it appears on `rxdma_byte` with `rxdma_valid` and `rxdma_addr` equal to the receive pointer. The pointer then rises by one and the count falls by one.
- R9: A write of length L to index 7, with C bytes queued, hands min(L,C) queued bytes to the DMA output, one per cycle from the next cycle on, at rising addresses. The outstanding count becomes L-C if L>C, else 0. Such a write is ignored while a hand-off is in progress.
- R10: A write to index 6 loads the receive pointer (read back at index 6), clears the outstanding receive count (read at index 7) and stops any hand-off.
- R11: A non-zero write N to index 5 pulses `dma_tx_go` in the next cycle with `dma_tx_len` = N and `dma_tx_base` = the transmit pointer (index 4), and advances that pointer by N. A zero write has no effect.
- R12: Indices above 8 read as zero, ignore writes and set `err_flag`, which stays set until reset.
- R13: The FIFO depth is `FIFO_DEPTH`, default 16. A value of zero or less selects 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word index (byte offset bits [11:2]) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |
| err_flag | output | 1 | Sticky undefined-index flag |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Received byte can be taken |
| dma_tx_go | output | 1 | Transmit DMA start strobe |
| dma_tx_base | output | DATA_W | Transmit DMA start address |
| dma_tx_len | output | DATA_W | Transmit DMA length |
| rxdma_valid | output | 1 | Receive DMA byte strobe |
| rxdma_addr | output | DATA_W | Receive DMA target address |
| rxdma_byte | output | 8 | Receive DMA byte |

## Verification
The checker watches, on every cycle, the relations that hold between neighbouring pieces of state. These are: the interrupt level against the enables, the FIFO count and the outstanding receive count; the FIFO count never passing its depth; the all-ones result of an empty data read; the one-cycle transmit strobe; the steering of an accepted byte to DMA; the gating of `rx_ready` during a hand-off; and the sticky error flag. Other behaviour needs a run of events, so only the bench scenarios can show it: byte order through FIFO wraparound, the exact bytes and addresses of a hand-off, the split of a receive length into handed-off and outstanding parts, the pointer arithmetic of both channels, and the depth substitution for a zero parameter.

// File: rtl/sport_pkg.sv
// Shared constants for the serial port register front-end: word indices
// of the register window and bit positions of the interrupt enable mask.
package sport_pkg;
    localparam int IDX_W = 10;

    localparam logic [IDX_W-1:0] RI_ID   = 10'd0;
    localparam logic [IDX_W-1:0] RI_DATA = 10'd1;
    localparam logic [IDX_W-1:0] RI_FCNT = 10'd2;
    localparam logic [IDX_W-1:0] RI_IEN  = 10'd3;
    localparam logic [IDX_W-1:0] RI_TXA  = 10'd4;
    localparam logic [IDX_W-1:0] RI_TXN  = 10'd5;
    localparam logic [IDX_W-1:0] RI_RXA  = 10'd6;
    localparam logic [IDX_W-1:0] RI_RXN  = 10'd7;
    localparam logic [IDX_W-1:0] RI_FSZ  = 10'd8;

    localparam int EN_FIFO = 0;
    localparam int EN_TX   = 1;
    localparam int EN_RX   = 2;
    localparam int EN_W    = 3;

    localparam int BYTE_W  = 8;
endpackage

// File: rtl/sport_rxq.sv
// Circular receive byte queue held as a read pointer plus a fill count.
// The write slot is (read pointer + count) wrapped at DEPTH, so any depth
// of two or more works. A push when full or a pop when empty is dropped.
// Assumes DEPTH >= 2 and CW wide enough to hold DEPTH.
module sport_rxq
    import sport_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5,
    parameter int PW    = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [CW-1:0]     count
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     rd_ptr;
    logic [PW-1:0]     wr_slot;
    logic              do_push;
    logic              do_pop;
    int unsigned       slot_i;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && (count != CW'(DEPTH));
    assign head    = mem[rd_ptr];

    // Compute the write slot as read pointer plus count, wrapped once.
    always_comb begin
        slot_i = int'(rd_ptr) + int'(count);
        if (slot_i >= DEPTH) slot_i = slot_i - DEPTH;
        wr_slot = PW'(slot_i);
    end

    // Store an accepted byte in its slot (storage needs no reset).
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_slot] <= push_data;
    end

    // Advance the read pointer on a pop and track the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/sport_irq.sv
// Combines the three separately enabled interrupt sources into one level.
// Assumes its inputs come from registers, so the output is glitch-tolerant.
module sport_irq
    import sport_pkg::*;
(
    input  logic [EN_W-1:0] enables,
    input  logic            fifo_has_data,
    input  logic            rx_rem_zero,
    output logic            irq
);
    // Raise the level when any enabled source is active.
    always_comb begin
        irq = (enables[EN_FIFO] && fifo_has_data)
           || enables[EN_TX]
           || (enables[EN_RX] && rx_rem_zero);
    end
endmodule

// File: rtl/sport_front.sv
// Register front-end of a serial port: word-indexed bus slave, receive
// FIFO, steering of received bytes to a pending receive DMA, hand-off of
// queued bytes when a receive DMA starts, and the transmit DMA start
// strobe. Assumes one bus access per cycle and DATA_W >= CW.
module sport_front
    import sport_pkg::*;
#(
    parameter logic [31:0] ID_VALUE   = 32'h5E12_0001,
    parameter int          FIFO_DEPTH = 16,
    parameter int          DATA_W     = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:2]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              err_flag,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              dma_tx_go,
    output logic [DATA_W-1:0] dma_tx_base,
    output logic [DATA_W-1:0] dma_tx_len,
    output logic              rxdma_valid,
    output logic [DATA_W-1:0] rxdma_addr,
    output logic [BYTE_W-1:0] rxdma_byte
);
    localparam int DEPTH = (FIFO_DEPTH <= 0) ? 16 : FIFO_DEPTH;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]  idx;
    logic              rd_acc, wr_acc, known;
    logic [EN_W-1:0]   int_en;
    logic [DATA_W-1:0] txa, rxa, rx_rem;
    logic [CW-1:0]     drain, fcnt;
    logic [BYTE_W-1:0] fhead;
    logic              draining, rxa_wr, rxn_wr, drain_step;
    logic              rx_fire, steer, q_push, q_pop, bus_pop;
    logic [DATA_W-1:0] rd_val;

    assign idx        = bus_addr;
    assign rd_acc     = bus_sel && !bus_wr;
    assign wr_acc     = bus_sel && bus_wr;
    assign known      = (idx <= RI_FSZ);
    assign draining   = (drain != '0);
    assign rxa_wr     = wr_acc && (idx == RI_RXA);
    assign rxn_wr     = wr_acc && (idx == RI_RXN);
    assign drain_step = draining && !rxa_wr;
    assign rx_ready   = !draining && !rxn_wr && ((rx_rem != '0) || (fcnt != CW'(DEPTH)));
    assign rx_fire    = rx_valid && rx_ready;
    assign steer      = rx_fire && (rx_rem != '0);
    assign q_push     = rx_fire && (rx_rem == '0);
    assign bus_pop    = rd_acc && (idx == RI_DATA) && !draining;
    assign q_pop      = bus_pop || drain_step;

    sport_rxq #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(rx_byte),
        .pop(q_pop), .head(fhead), .count(fcnt)
    );

    sport_irq u_irq (
        .enables(int_en), .fifo_has_data(fcnt != '0),
        .rx_rem_zero(rx_rem == '0), .irq(irq)
    );

    // Select the read value for the addressed word.
    always_comb begin
        case (idx)
            RI_ID:   rd_val = DATA_W'(ID_VALUE);
            RI_DATA: rd_val = (!draining && fcnt != '0) ? DATA_W'(fhead) : '1;
            RI_FCNT: rd_val = DATA_W'(fcnt);
            RI_IEN:  rd_val = DATA_W'(int_en);
            RI_TXA:  rd_val = txa;
            RI_TXN:  rd_val = '0;
            RI_RXA:  rd_val = rxa;
            RI_RXN:  rd_val = rx_rem;
            RI_FSZ:  rd_val = DATA_W'(DEPTH);
            default: rd_val = '0;
        endcase
    end

    // Capture read data and the sticky undefined-index flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            err_flag  <= 1'b0;
        end else begin
            if (rd_acc) bus_rdata <= rd_val;
            if (bus_sel && !known) err_flag <= 1'b1;
        end
    end

    // Hold the interrupt enable mask and emit transmit bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en   <= '0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            if (wr_acc && idx == RI_IEN) int_en <= bus_wdata[EN_W-1:0];
            tx_valid <= wr_acc && (idx == RI_DATA);
            if (wr_acc && idx == RI_DATA) tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    // Transmit DMA pointer and start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txa         <= '0;
            dma_tx_go   <= 1'b0;
            dma_tx_base <= '0;
            dma_tx_len  <= '0;
        end else begin
            dma_tx_go <= 1'b0;
            if (wr_acc && idx == RI_TXA) begin
                txa <= bus_wdata;
            end else if (wr_acc && idx == RI_TXN && bus_wdata != '0) begin
                dma_tx_go   <= 1'b1;
                dma_tx_base <= txa;
                dma_tx_len  <= bus_wdata;
                txa         <= txa + bus_wdata;
            end
        end
    end

    // Receive DMA pointer, outstanding count, hand-off and steering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxa         <= '0;
            rx_rem      <= '0;
            drain       <= '0;
            rxdma_valid <= 1'b0;
            rxdma_addr  <= '0;
            rxdma_byte  <= '0;
        end else begin
            rxdma_valid <= 1'b0;
            if (rxa_wr) begin
                rxa    <= bus_wdata;
                rx_rem <= '0;
                drain  <= '0;
            end else if (rxn_wr && !draining) begin
                if (bus_wdata > DATA_W'(fcnt)) begin
                    rx_rem <= bus_wdata - DATA_W'(fcnt);
                    drain  <= fcnt;
                end else begin
                    rx_rem <= '0;
                    drain  <= CW'(bus_wdata);
                end
            end else if (drain_step) begin
                rxdma_valid <= 1'b1;
                rxdma_byte  <= fhead;
                rxdma_addr  <= rxa;
                rxa         <= rxa + 1'b1;
                drain       <= drain - 1'b1;
            end else if (steer) begin
                rxdma_valid <= 1'b1;
                rxdma_byte  <= rx_byte;
                rxdma_addr  <= rxa;
                rxa         <= rxa + 1'b1;
                rx_rem      <= rx_rem - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sport_front_chk.sv
// Cycle-by-cycle properties of the serial port front-end, bound to every
// instance of sport_front. Assumes a synchronous active-low reset.
module sport_front_chk
    import sport_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CW     = 5,
    parameter int DATA_W = 32
)(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [11:2]       bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              err_flag,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rxdma_valid,
    input logic [EN_W-1:0]   int_en,
    input logic [CW-1:0]     fcnt,
    input logic [DATA_W-1:0] rx_rem,
    input logic [CW-1:0]     drain
);
    // R7
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt <= CW'(DEPTH));

    // R5
    irq_sources_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((int_en[EN_FIFO] && fcnt != '0) || int_en[EN_TX]
                || (int_en[EN_RX] && rx_rem == '0)));

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == RI_DATA && fcnt == '0) |=> (bus_rdata == '1));

    // R6
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == RI_DATA)
        |=> (tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0])));

    // R7
    rx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_rem == '0 && !(bus_sel && !bus_wr && bus_addr == RI_DATA))
        |=> (fcnt == CW'($past(fcnt) + 1'b1)));

    // R8
    steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_rem != '0 && !(bus_sel && bus_wr && bus_addr == RI_RXA))
        |=> (rxdma_valid && rx_rem == $past(rx_rem) - 1'b1));

    // R9
    drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain != '0) |-> !rx_ready);

    // R12
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr > RI_FSZ) |=> err_flag);

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind sport_front sport_front_chk #(.DEPTH(DEPTH), .CW(CW), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .err_flag(err_flag), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rxdma_valid(rxdma_valid),
    .int_en(int_en), .fcnt(fcnt), .rx_rem(rx_rem), .drain(drain)
);

// File: tb/sim_sport_front.sv
`timescale 1ns/1ps
module sim_sport_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;

    logic [31:0] bus_rdata, dma_tx_base, dma_tx_len, rxdma_addr;
    logic        irq, err_flag, tx_valid, rx_ready, dma_tx_go, rxdma_valid;
    logic [7:0]  tx_byte, rxdma_byte;

    logic [31:0] u1_rdata, u1_tb, u1_tl, u1_ra;
    logic        u1_irq, u1_err, u1_tv, u1_rr, u1_go, u1_rv;
    logic [7:0]  u1_tx, u1_rb;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [$];

    always #2 clk = ~clk;

    sport_front u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .err_flag(err_flag), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .dma_tx_go(dma_tx_go), .dma_tx_base(dma_tx_base), .dma_tx_len(dma_tx_len),
        .rxdma_valid(rxdma_valid), .rxdma_addr(rxdma_addr), .rxdma_byte(rxdma_byte)
    );

    sport_front #(.FIFO_DEPTH(0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(u1_rdata),
        .irq(u1_irq), .err_flag(u1_err), .tx_valid(u1_tv), .tx_byte(u1_tx),
        .rx_valid(1'b0), .rx_byte(8'h00), .rx_ready(u1_rr),
        .dma_tx_go(u1_go), .dma_tx_base(u1_tb), .dma_tx_len(u1_tl),
        .rxdma_valid(u1_rv), .rxdma_addr(u1_ra), .rxdma_byte(u1_rb)
    );

    typedef struct packed {
        logic        wr;
        logic [9:0]  idx;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'd0, 32'h0,         1'b1, 32'h5E12_0001, 4'd2},  // R2 id
        '{1'b0, 10'd8, 32'h0,         1'b1, 32'd16,        4'd2},  // R2 depth
        '{1'b0, 10'd5, 32'h0,         1'b1, 32'h0,         4'd2},  // R2 tx count reads 0
        '{1'b0, 10'd2, 32'h0,         1'b1, 32'h0,         4'd1},  // R1 fifo empty
        '{1'b0, 10'd7, 32'h0,         1'b1, 32'h0,         4'd1},  // R1 rx count zero
        '{1'b0, 10'd1, 32'h0,         1'b1, 32'hFFFF_FFFF, 4'd4},  // R4 empty read
        '{1'b0, 10'd2, 32'h0,         1'b1, 32'h0,         4'd4},  // R4 count unchanged
        '{1'b1, 10'd3, 32'hFFFF_FFF8, 1'b0, 32'h0,         4'd5},
        '{1'b0, 10'd3, 32'h0,         1'b1, 32'h0,         4'd5},  // R5 only 3 bits kept
        '{1'b1, 10'd4, 32'h0000_1000, 1'b0, 32'h0,         4'd11},
        '{1'b1, 10'd5, 32'h0000_0020, 1'b0, 32'h0,         4'd11},
        '{1'b0, 10'd4, 32'h0,         1'b1, 32'h0000_1020, 4'd11}, // R11 pointer advanced
        '{1'b1, 10'd5, 32'h0,         1'b0, 32'h0,         4'd11},
        '{1'b0, 10'd4, 32'h0,         1'b1, 32'h0000_1020, 4'd11}, // R11 zero length
        '{1'b1, 10'd6, 32'h0000_2000, 1'b0, 32'h0,         4'd10},
        '{1'b0, 10'd6, 32'h0,         1'b1, 32'h0000_2000, 4'd10}, // R10 rx pointer
        '{1'b0, 10'd9, 32'h0,         1'b1, 32'h0,         4'd12}, // R12 undefined reads 0
        '{1'b1, 10'd63, 32'h5,        1'b0, 32'h0,         4'd12},
        '{1'b0, 10'd3, 32'h0,         1'b1, 32'h0,         4'd12}  // R12 write ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [9:0] idx, input logic [31:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = idx; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic push_model(input logic [7:0] b);
        rx_send(b);
        model.push_back(b);
    endtask

    task automatic pop_check(input string req);
        logic [7:0] e;
        e = model.pop_front();
        bus_op(1'b0, 10'd1, 32'h0);
        check(req, bus_rdata, {24'h0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 err", {31'h0, err_flag}, 32'h0);
        check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        check("R1 rxdma_valid", {31'h0, rxdma_valid}, 32'h0);
        check("R1 dma_tx_go", {31'h0, dma_tx_go}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].wr, VECS[i].idx, VECS[i].wdata);
            if (VECS[i].chk) check($sformatf("R%0d vector %0d", VECS[i].req, i), bus_rdata, VECS[i].exp);
        end

        // R13 zero depth parameter falls back to 16
        bus_op(1'b0, 10'd8, 32'h0);
        check("R13 depth", u1_rdata, 32'd16);

        // R5 interrupt sources
        bus_op(1'b1, 10'd3, 32'h1);
        check("R5 fifo src empty", {31'h0, irq}, 32'h0);
        push_model(8'h5A);
        check("R5 fifo src data", {31'h0, irq}, 32'h1);
        pop_check("R3 single pop");
        check("R5 fifo src drained", {31'h0, irq}, 32'h0);
        bus_op(1'b1, 10'd3, 32'h2);
        check("R5 tx src", {31'h0, irq}, 32'h1);
        bus_op(1'b1, 10'd3, 32'h4);
        check("R5 rx src zero count", {31'h0, irq}, 32'h1);
        bus_op(1'b1, 10'd3, 32'h0);
        check("R5 all off", {31'h0, irq}, 32'h0);

        // R6 transmit strobe
        bus_op(1'b1, 10'd1, 32'h0000_01A5);
        check("R6 tx_valid", {31'h0, tx_valid}, 32'h1);
        check("R6 tx_byte", {24'h0, tx_byte}, 32'hA5);
        @(negedge clk);
        check("R6 tx one cycle", {31'h0, tx_valid}, 32'h0);

        // R7 and R3 fill to depth, overflow refused, order kept
        for (int i = 0; i < 16; i++) push_model(8'(i * 3 + 1));
        check("R7 ready low full", {31'h0, rx_ready}, 32'h0);
        rx_send(8'hEE);
        bus_op(1'b0, 10'd2, 32'h0);
        check("R7 full count", bus_rdata, 32'd16);
        for (int i = 0; i < 16; i++) pop_check("R3 order");
        bus_op(1'b0, 10'd1, 32'h0);
        check("R4 empty after drain", bus_rdata, 32'hFFFF_FFFF);

        // R3 wraparound
        for (int i = 0; i < 5; i++) push_model(8'(8'h80 + i));
        for (int i = 0; i < 3; i++) pop_check("R3 wrap pop");
        for (int i = 0; i < 14; i++) push_model(8'(8'hC0 + i));
        check("R7 ready low after wrap", {31'h0, rx_ready}, 32'h0);
        for (int i = 0; i < 16; i++) pop_check("R3 wrap order");

        // R9 hand-off with length above queued count, then R8 steering
        bus_op(1'b1, 10'd3, 32'h4);
        for (int i = 0; i < 3; i++) push_model(8'(8'h10 + i));
        bus_op(1'b1, 10'd6, 32'h0000_3000);
        bus_op(1'b1, 10'd7, 32'd5);
        check("R9 ready low during hand-off", {31'h0, rx_ready}, 32'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 hand-off valid", {31'h0, rxdma_valid}, 32'h1);
            check("R9 hand-off byte", {24'h0, rxdma_byte}, {24'h0, model.pop_front()});
            check("R9 hand-off addr", rxdma_addr, 32'h3000 + 32'(k));
        end
        check("R7 ready with count outstanding", {31'h0, rx_ready}, 32'h1);
        check("R5 rx src busy", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R9 hand-off ends", {31'h0, rxdma_valid}, 32'h0);
        bus_op(1'b0, 10'd7, 32'h0);
        check("R9 outstanding", bus_rdata, 32'd2);
        rx_send(8'h61);
        check("R8 steer valid", {31'h0, rxdma_valid}, 32'h1);
        check("R8 steer byte", {24'h0, rxdma_byte}, 32'h61);
        check("R8 steer addr", rxdma_addr, 32'h3003);
        rx_send(8'h62);
        check("R8 steer addr 2", rxdma_addr, 32'h3004);
        check("R5 rx src done", {31'h0, irq}, 32'h1);
        bus_op(1'b0, 10'd2, 32'h0);
        check("R8 fifo untouched", bus_rdata, 32'h0);
        bus_op(1'b0, 10'd6, 32'h0);
        check("R8 pointer", bus_rdata, 32'h3005);

        // R10 cancel of outstanding count
        bus_op(1'b1, 10'd7, 32'd3);
        bus_op(1'b0, 10'd7, 32'h0);
        check("R9 empty fifo outstanding", bus_rdata, 32'd3);
        bus_op(1'b1, 10'd6, 32'h0000_4000);
        bus_op(1'b0, 10'd7, 32'h0);
        check("R10 count cleared", bus_rdata, 32'h0);
        bus_op(1'b0, 10'd6, 32'h0);
        check("R10 pointer loaded", bus_rdata, 32'h4000);
        push_model(8'h77);
        check("R10 byte not steered", {31'h0, rxdma_valid}, 32'h0);
        pop_check("R10 byte queued");

        // R9 hand-off with length below queued count
        for (int i = 0; i < 4; i++) push_model(8'(8'h21 + i));
        bus_op(1'b1, 10'd7, 32'd2);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check("R9 short byte", {24'h0, rxdma_byte}, {24'h0, model.pop_front()});
            check("R9 short addr", rxdma_addr, 32'h4000 + 32'(k));
        end
        bus_op(1'b0, 10'd7, 32'h0);
        check("R9 short outstanding", bus_rdata, 32'h0);
        bus_op(1'b0, 10'd2, 32'h0);
        check("R9 short remaining", bus_rdata, 32'd2);
        pop_check("R9 next byte");
        pop_check("R9 last byte");

        // R11 transmit DMA start strobe
        bus_op(1'b1, 10'd4, 32'h0000_0500);
        bus_op(1'b1, 10'd5, 32'd7);
        check("R11 go", {31'h0, dma_tx_go}, 32'h1);
        check("R11 len", dma_tx_len, 32'd7);
        check("R11 base", dma_tx_base, 32'h500);
        @(negedge clk);
        check("R11 go one cycle", {31'h0, dma_tx_go}, 32'h0);
        bus_op(1'b1, 10'd5, 32'd0);
        check("R11 zero no go", {31'h0, dma_tx_go}, 32'h0);
        bus_op(1'b0, 10'd4, 32'h0);
        check("R11 pointer", bus_rdata, 32'h507);

        // R12 flag still set
        check("R12 sticky", {31'h0, err_flag}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule